// File: doc/BRIEF.md
# Translation Descriptor Classifier

This block sits after the descriptor fetch stage of a page-table walker. Each valid cycle it takes one 64-bit translation descriptor together with three pieces of context: the lookup level (0 to 3) at which the descriptor was read, the log2 of the translation granule, and the virtual address being translated. It decides whether the descriptor is invalid, points to a next-level table, maps a block, or maps a page.

For a block or a page, the block reports how many low address bits pass straight through from the virtual address. It also builds the output physical address. For a table, it reports the base address of the next table. Whether a block is legal depends on both the granule and the level, and so does the width of the block offset.

The results are registered and appear one cycle after the input, marked by `out_valid`.

Top module: `desc_classifier`

## Requirements
- R1: `out_kind` uses the codes 0 = invalid, 1 = table, 2 = block, 3 = page. A descriptor whose bits [1:0] are 00 or 10 is classified invalid at every level.
- R2: A descriptor with bits [1:0] = 11 is a table at levels 0, 1 and 2, and a page at level 3.
- R3: With the 4 KB granule (log2 12), a descriptor with bits [1:0] = 01 is a block at levels 1 and 2, and invalid at levels 0 and 3.
- R4: With the 16 KB or 64 KB granule (log2 14 or 16), a descriptor with bits [1:0] = 01 is a block only at level 2, and invalid at levels 0, 1 and 3.
- R5: Block offset widths depend on granule and level:
  - 4 KB granule: 30 at level 1 and 21 at level 2.
  - 16 KB granule: 25.
  - 64 KB granule: 29.
- R6: For a page, `out_ofs_w` equals the granule log2 (12, 14 or 16). For a table, `out_ofs_w` is 0.
- R7: For a block or a page with offset width w, `out_pa` is descriptor bits [47:w] concatenated with vaddr bits [w-1:0]. `out_next_base` is 0 for blocks and pages.
- R8: For a table, `out_next_base` is descriptor bits [47:g] with bits [g-1:0] cleared, where g is the granule log2. `out_pa` is 0 for tables.
- R9: For an invalid result, `out_ofs_w`, `out_pa` and `out_next_base` are all 0.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, the result outputs keep their previous values.
- R11: Any `in_gran_log2` value other than 14 or 16 is treated as the 4 KB granule (log2 12).
- R12: While reset is asserted and right after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input descriptor is present this cycle |
| in_desc | input | 64 | Translation descriptor |
| in_level | input | 2 | Lookup level 0..3 |
| in_gran_log2 | input | 5 | Granule size as log2 (12, 14, 16) |
| in_vaddr | input | 48 | Virtual address being translated |
| out_valid | output | 1 | Result registered from previous input |
| out_kind | output | 2 | 0 invalid, 1 table, 2 block, 3 page |
| out_ofs_w | output | 5 | Offset width in bits for block or page |
| out_pa | output | 48 | Output physical address |
| out_next_base | output | 48 | Next-level table base address |

## Verification
The hardest situations to reach are the block candidates that are illegal only because of the granule and level together, such as a level-1 block under the 16 KB or 64 KB granule. Uniform random descriptors hit each granule/level/type combination only rarely. The stimulus therefore picks the low two descriptor bits, the level and the granule as separate small random choices, so every combination recurs many times. Directed cases pin each (granule, level) block pair, reserved granule codes, and idle cycles in which the inputs change while the outputs must hold.

// File: rtl/desc_classifier_pkg.sv
package desc_classifier_pkg;

    typedef enum logic [1:0] {
        KIND_INVALID = 2'd0,
        KIND_TABLE   = 2'd1,
        KIND_BLOCK   = 2'd2,
        KIND_PAGE    = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        GR_4K  = 2'd0,
        GR_16K = 2'd1,
        GR_64K = 2'd2
    } gran_e;

    localparam int OFS_W = 5;

    // Offset widths as log2 values
    localparam logic [OFS_W-1:0] LOG2_4K        = 5'd12;
    localparam logic [OFS_W-1:0] LOG2_16K       = 5'd14;
    localparam logic [OFS_W-1:0] LOG2_64K       = 5'd16;
    localparam logic [OFS_W-1:0] BLK_4K_LVL1    = 5'd30;
    localparam logic [OFS_W-1:0] BLK_4K_LVL2    = 5'd21;
    localparam logic [OFS_W-1:0] BLK_16K        = 5'd25;
    localparam logic [OFS_W-1:0] BLK_64K        = 5'd29;

endpackage

// File: rtl/desc_granule_norm.sv
module desc_granule_norm
    import desc_classifier_pkg::*;
#(
    parameter int G_W = 5
) (
    input  logic [G_W-1:0]   gran_log2,
    output gran_e            gran,
    output logic [OFS_W-1:0] gran_bits
);
    always_comb begin
        unique case (gran_log2)
            G_W'(14): begin
                gran      = GR_16K;
                gran_bits = LOG2_16K;
            end
            G_W'(16): begin
                gran      = GR_64K;
                gran_bits = LOG2_64K;
            end
            default: begin
                gran      = GR_4K;
                gran_bits = LOG2_4K;
            end
        endcase
    end
endmodule

// File: rtl/desc_kind_decode.sv
module desc_kind_decode
    import desc_classifier_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic [1:0]       low_bits,
    input  logic [LVL_W-1:0] level,
    input  gran_e            gran,
    output kind_e            kind
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(3);

    logic block_ok;

    always_comb begin
        if (gran == GR_4K) begin
            block_ok = (level == LVL_W'(1)) || (level == LVL_W'(2));
        end else begin
            block_ok = (level == LVL_W'(2));
        end

        unique case (low_bits)
            2'b01:   kind = block_ok ? KIND_BLOCK : KIND_INVALID;
            2'b11:   kind = (level == LAST_LVL) ? KIND_PAGE : KIND_TABLE;
            default: kind = KIND_INVALID;
        endcase
    end
endmodule

// File: rtl/desc_offset_width.sv
module desc_offset_width
    import desc_classifier_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  kind_e            kind,
    input  logic [LVL_W-1:0] level,
    input  gran_e            gran,
    input  logic [OFS_W-1:0] gran_bits,
    output logic [OFS_W-1:0] ofs_w
);
    logic [OFS_W-1:0] blk_w;

    always_comb begin
        unique case (gran)
            GR_16K:  blk_w = BLK_16K;
            GR_64K:  blk_w = BLK_64K;
            default: blk_w = (level == LVL_W'(1)) ? BLK_4K_LVL1 : BLK_4K_LVL2;
        endcase

        unique case (kind)
            KIND_BLOCK: ofs_w = blk_w;
            KIND_PAGE:  ofs_w = gran_bits;
            default:    ofs_w = '0;
        endcase
    end
endmodule

// File: rtl/desc_addr_former.sv
module desc_addr_former
    import desc_classifier_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  kind_e            kind,
    input  logic [PA_W-1:0]  desc_addr,
    input  logic [PA_W-1:0]  vaddr,
    input  logic [OFS_W-1:0] ofs_w,
    input  logic [OFS_W-1:0] gran_bits,
    output logic [PA_W-1:0]  pa,
    output logic [PA_W-1:0]  next_base
);
    logic [PA_W-1:0] ofs_mask;
    logic [PA_W-1:0] gran_mask;

    // One comparator per bit position, so the mask costs no shifter
    for (genvar i = 0; i < PA_W; i++) begin : g_mask
        assign ofs_mask[i]  = (i < int'(ofs_w));
        assign gran_mask[i] = (i < int'(gran_bits));
    end

    always_comb begin
        pa        = '0;
        next_base = '0;
        unique case (kind)
            KIND_BLOCK, KIND_PAGE: pa = (desc_addr & ~ofs_mask) | (vaddr & ofs_mask);
            KIND_TABLE:            next_base = desc_addr & ~gran_mask;
            default: ;
        endcase
    end
endmodule

// File: rtl/desc_classifier.sv
module desc_classifier
    import desc_classifier_pkg::*;
#(
    parameter int DESC_W = 64,
    parameter int PA_W   = 48,
    parameter int LVL_W  = 2,
    parameter int G_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DESC_W-1:0] in_desc,
    input  logic [LVL_W-1:0]  in_level,
    input  logic [G_W-1:0]    in_gran_log2,
    input  logic [PA_W-1:0]   in_vaddr,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [OFS_W-1:0]  out_ofs_w,
    output logic [PA_W-1:0]   out_pa,
    output logic [PA_W-1:0]   out_next_base
);
    typedef struct packed {
        logic              vld;
        kind_e             kind;
        logic [OFS_W-1:0]  ofs_w;
        logic [PA_W-1:0]   pa;
        logic [PA_W-1:0]   base;
    } res_t;

    gran_e            gran;
    logic [OFS_W-1:0] gran_bits;
    kind_e            kind;
    logic [OFS_W-1:0] ofs_w;
    logic [PA_W-1:0]  pa;
    logic [PA_W-1:0]  base;

    res_t res_d, res_q;

    desc_granule_norm #(.G_W(G_W)) u_gran (
        .gran_log2 (in_gran_log2),
        .gran      (gran),
        .gran_bits (gran_bits)
    );

    desc_kind_decode #(.LVL_W(LVL_W)) u_kind (
        .low_bits (in_desc[1:0]),
        .level    (in_level),
        .gran     (gran),
        .kind     (kind)
    );

    desc_offset_width #(.LVL_W(LVL_W)) u_ofs (
        .kind      (kind),
        .level     (in_level),
        .gran      (gran),
        .gran_bits (gran_bits),
        .ofs_w     (ofs_w)
    );

    desc_addr_former #(.PA_W(PA_W)) u_addr (
        .kind      (kind),
        .desc_addr (in_desc[PA_W-1:0]),
        .vaddr     (in_vaddr),
        .ofs_w     (ofs_w),
        .gran_bits (gran_bits),
        .pa        (pa),
        .next_base (base)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.kind  = kind;
            res_d.ofs_w = ofs_w;
            res_d.pa    = pa;
            res_d.base  = base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid     = res_q.vld;
    assign out_kind      = res_q.kind;
    assign out_ofs_w     = res_q.ofs_w;
    assign out_pa        = res_q.pa;
    assign out_next_base = res_q.base;
endmodule

// File: rtl/desc_classifier_checker.sv
module desc_classifier_checker #(
    parameter int DESC_W = 64,
    parameter int PA_W   = 48,
    parameter int LVL_W  = 2,
    parameter int G_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DESC_W-1:0] in_desc,
    input logic [LVL_W-1:0]  in_level,
    input logic [G_W-1:0]    in_gran_log2,
    input logic              out_valid,
    input logic [1:0]        out_kind,
    input logic [4:0]        out_ofs_w,
    input logic [PA_W-1:0]   out_pa,
    input logic [PA_W-1:0]   out_next_base
);
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_pa) && $stable(out_kind)));

    p_even_low_invalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_desc[0]) |=> (out_kind == 2'd0));

    p_last_lvl_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_desc[1:0] == 2'b11 && in_level == LVL_W'(3)) |=> (out_kind == 2'd3));

    p_lvl0_no_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_level == '0) |=> (out_kind != 2'd2));

    p_big_gran_lvl1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_level == LVL_W'(1) &&
         (in_gran_log2 == G_W'(14) || in_gran_log2 == G_W'(16))) |=> (out_kind != 2'd2));

    p_invalid_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd0) |->
            (out_ofs_w == '0 && out_pa == '0 && out_next_base == '0));

    p_table_no_pa_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd1) |-> (out_pa == '0 && out_ofs_w == '0));
endmodule

bind desc_classifier desc_classifier_checker #(
    .DESC_W (DESC_W),
    .PA_W   (PA_W),
    .LVL_W  (LVL_W),
    .G_W    (G_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_desc       (in_desc),
    .in_level      (in_level),
    .in_gran_log2  (in_gran_log2),
    .out_valid     (out_valid),
    .out_kind      (out_kind),
    .out_ofs_w     (out_ofs_w),
    .out_pa        (out_pa),
    .out_next_base (out_next_base)
);

// File: tb/desc_classifier_test.sv
`timescale 1ns/1ps
module desc_classifier_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_desc = '0;
    logic [1:0]  in_level = '0;
    logic [4:0]  in_gran_log2 = 5'd12;
    logic [47:0] in_vaddr = '0;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [4:0]  out_ofs_w;
    logic [47:0] out_pa;
    logic [47:0] out_next_base;

    int checks = 0;
    int errors = 0;
    int seed_dummy;

    always #10 clk = ~clk;

    desc_classifier uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_desc(in_desc),
        .in_level(in_level), .in_gran_log2(in_gran_log2), .in_vaddr(in_vaddr),
        .out_valid(out_valid), .out_kind(out_kind), .out_ofs_w(out_ofs_w),
        .out_pa(out_pa), .out_next_base(out_next_base)
    );

    // Reference model built from the requirements
    function automatic logic [1:0] ref_kind(logic [1:0] lo, logic [1:0] lvl, int g);
        if (lo == 2'b11) return (lvl == 2'd3) ? 2'd3 : 2'd1;             // R2
        if (lo == 2'b01) begin
            if (g == 12) return (lvl == 2'd1 || lvl == 2'd2) ? 2'd2 : 2'd0; // R3
            return (lvl == 2'd2) ? 2'd2 : 2'd0;                           // R4
        end
        return 2'd0;                                                       // R1
    endfunction

    function automatic int norm_g(logic [4:0] g);
        if (g == 5'd14) return 14;
        if (g == 5'd16) return 16;
        return 12;                                                         // R11
    endfunction

    function automatic int ref_ofs(logic [1:0] k, logic [1:0] lvl, int g);
        if (k == 2'd3) return g;                                           // R6
        if (k == 2'd2) begin                                               // R5
            if (g == 14) return 25;
            if (g == 16) return 29;
            return (lvl == 2'd1) ? 30 : 21;
        end
        return 0;
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_one(logic [63:0] d, logic [1:0] lvl, logic [4:0] g, logic [47:0] va, string req);
        logic [1:0]  ek;
        int          eo;
        int          gn;
        logic [47:0] mask;
        logic [47:0] epa;
        logic [47:0] ebase;
        gn = norm_g(g);
        ek = ref_kind(d[1:0], lvl, gn);
        eo = ref_ofs(ek, lvl, gn);
        mask  = (48'd1 << eo) - 48'd1;
        epa   = (ek == 2'd2 || ek == 2'd3) ? ((d[47:0] & ~mask) | (va & mask)) : 48'd0;      // R7
        ebase = (ek == 2'd1) ? (d[47:0] & ~((48'd1 << gn) - 48'd1)) : 48'd0;               // R8
        @(negedge clk);
        in_valid = 1'b1; in_desc = d; in_level = lvl; in_gran_log2 = g; in_vaddr = va;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10", "out_valid", {63'd0, out_valid}, 64'd1);
        check(req, "kind", {62'd0, out_kind}, {62'd0, ek});
        check(req, "ofs_w", {59'd0, out_ofs_w}, 64'(eo));
        check((ek == 2'd0) ? "R9" : "R7", "pa", {16'd0, out_pa}, {16'd0, epa});
        check((ek == 2'd0) ? "R9" : "R8", "next_base", {16'd0, out_next_base}, {16'd0, ebase});
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] hold_pa;
        logic [1:0]  hold_k;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "out_valid", {63'd0, out_valid}, 64'd0);
        check("R12", "kind", {62'd0, out_kind}, 64'd0);
        check("R12", "pa", {16'd0, out_pa}, 64'd0);
        check("R12", "base", {16'd0, out_next_base}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "out_valid after reset", {63'd0, out_valid}, 64'd0);

        // Directed: every block-candidate granule/level pair (R3, R4, R5)
        for (int gi = 0; gi < 3; gi++) begin
            for (int l = 0; l < 4; l++) begin
                run_one(64'hFFFF_89AB_CDEF_1235, 2'(l), 5'(12 + 2*gi), 48'h7654_3210_FEDC,
                        (gi == 0) ? "R3" : "R4");
            end
        end
        // R1: even low bits
        run_one(64'h0000_1234_5678_9000, 2'd2, 5'd12, 48'h1, "R1");
        run_one(64'h0000_1234_5678_9002, 2'd3, 5'd16, 48'h1, "R1");
        // R2 and R6: table and page
        run_one(64'h0000_ABCD_EF12_3FFF, 2'd0, 5'd16, 48'hFFFF_FFFF_FFFF, "R2");
        run_one(64'h0000_ABCD_EF12_3FFF, 2'd3, 5'd14, 48'hFFFF_FFFF_FFFF, "R6");
        // R11: reserved granule codes act as 4 KB
        run_one(64'h0000_0000_4000_0001, 2'd1, 5'd0, 48'h3FFF_FFFF, "R11");
        run_one(64'h0000_0000_0000_3003, 2'd3, 5'd15, 48'hFFF, "R11");

        // R10: idle cycle with changing inputs holds outputs
        run_one(64'h0000_1111_2222_3003, 2'd3, 5'd12, 48'h0ABC, "R6");
        hold_pa = out_pa; hold_k = out_kind;
        in_desc = 64'h0; in_level = 2'd0; in_vaddr = 48'hFFFF;
        @(negedge clk);
        check("R10", "out_valid idle", {63'd0, out_valid}, 64'd0);
        check("R10", "pa held", {16'd0, out_pa}, {16'd0, hold_pa});
        check("R10", "kind held", {62'd0, out_kind}, {62'd0, hold_k});

        // Constrained random
        for (int n = 0; n < 400; n++) begin
            logic [63:0] d;
            logic [4:0]  g;
            int          sel;
            d = {$urandom, $urandom};
            d[1:0] = 2'($urandom_range(0, 3));
            sel = $urandom_range(0, 9);
            g = (sel < 3) ? 5'd12 : (sel < 6) ? 5'd14 : (sel < 9) ? 5'd16 : 5'($urandom);
            run_one(d, 2'($urandom_range(0, 3)), g, {16'($urandom), $urandom},
                    (d[1:0] == 2'b01) ? "R5" : "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule